// File: doc/BRIEF.md
# Dual-Phase Thermometer Edge Encoder

This block sits behind a tapped delay line. The line's taps are sampled on a fast clock that runs at twice the rate of the buffer clock. On every fast cycle the encoder takes one 128-tap thermometer snapshot and looks for the earliest genuine low-to-high transition in it. A tree search returns the position of that transition as a 7-bit number.

Two consecutive fast samples form one buffer-clock period: the sample taken with `phase_i` low comes first, and the one taken with `phase_i` high comes second. The encoder merges the results of the two samples into a single word, using an eighth bit to say which half held the reported edge. If both halves contain an edge, only the earlier one is reported. This stops a line that is slightly longer than one fast period from producing a second hit for the same event.

The merged word is registered once per pair and then held for two fast cycles, so logic in the half-rate domain always reads a settled value. `phase_i` is expected to alternate on every fast clock edge.

Top module: `dual_phase_edge_enc`

## Requirements
- R1: While `rst_ni` is low, `hit_o` is 0 and `code_o` is 0.
- R2: A transition at tap k (0 to 125) exists only when tap k is 0 and taps k+1 and k+2 are both 1. The value k appears on `code_o[6:0]`. A lone high tap with low neighbours on both sides is not a transition.
- R3: When a snapshot holds several transitions, the lowest tap index is reported.
- R4: `code_o[7]` is 0 when the reported edge came from the sample taken with `phase_i` low. It is 1 when the edge came from the sample taken with `phase_i` high.
- R5: When both samples of a pair contain a transition, only the one from the `phase_i`-low sample is reported.
- R6: When neither sample of a pair contains a transition, `hit_o` is 0 and `code_o` is 0.
- R7: The result of a pair appears on the outputs three rising edges after the edge that captures the pair's `phase_i`-high sample. It stays unchanged across the next edge.
- R8: Tap 0 (code 0) and tap 125 (code 125) are reportable. A 0-to-1 step between taps 126 and 127 is not a transition, because it lacks a second high tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 128 | Thermometer snapshot of the delay-line taps |
| phase_i | input | 1 | Fast-clock phase within the buffer period: 0 for the first sample, 1 for the second |
| code_o | output | 8 | Bit 7 is the phase of the reported edge; bits 6:0 are the tap position |
| hit_o | output | 1 | A transition was found in the pair |

## Verification
The bench targets four kinds of error:
- A detector that accepts a single-tap bubble would report a phantom hit at the bubble.
- An encoder that favours the higher index would return the later of two transitions.
- A merge that does not give the first half priority would report the second half's edge, with bit 7 set, when both halves fire.
- An off-by-one in the pipeline depth would shift every result by one fast cycle, or let a result change on the phase-low edge; the bench compares the outputs on every cycle against a queue-based model.

The boundary taps 0, 125 and 126 are driven directly, so a window that is trimmed wrongly at either end of the line is caught.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;
  parameter int TAPS_DEF = 128;
  localparam int POS_W_DEF = $clog2(TAPS_DEF);
  localparam int EDGE_SPAN = 3;  // taps examined per transition candidate
endpackage

// File: rtl/edge_flags.sv
module edge_flags #(
  parameter int TAPS = tdc_enc_pkg::TAPS_DEF
) (
  input  logic [TAPS-1:0] therm_i,
  output logic [TAPS-1:0] flag_o
);
  localparam int LAST = TAPS - tdc_enc_pkg::EDGE_SPAN;

  // A candidate needs one low tap followed by two high taps, which rejects single-tap bubbles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k <= LAST) begin : g_cand
      assign flag_o[k] = ~therm_i[k] & therm_i[k+1] & therm_i[k+2];
    end else begin : g_edge
      assign flag_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/first_edge_tree.sv
module first_edge_tree #(
  parameter int N     = tdc_enc_pkg::TAPS_DEF,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     flags_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int LVLS = $clog2(N);

  // Halving tree: at each node the lower half wins when it holds any flag
  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int NODES = N >> l;
    logic [NODES-1:0]       v;
    logic [NODES*IDX_W-1:0] ix;
    if (l == 0) begin : g_leaf
      assign v = flags_i;
      for (genvar n = 0; n < NODES; n++) begin : g_n
        assign ix[n*IDX_W +: IDX_W] = IDX_W'(n);
      end
    end else begin : g_node
      for (genvar n = 0; n < NODES; n++) begin : g_n
        logic lo_v;
        assign lo_v = g_lvl[l-1].v[2*n];
        assign v[n] = lo_v | g_lvl[l-1].v[2*n+1];
        assign ix[n*IDX_W +: IDX_W] = lo_v ? g_lvl[l-1].ix[2*n*IDX_W +: IDX_W]
                                           : g_lvl[l-1].ix[(2*n+1)*IDX_W +: IDX_W];
      end
    end
  end

  assign found_o = g_lvl[LVLS].v[0];
  assign idx_o   = g_lvl[LVLS].ix[IDX_W-1:0];

  always_comb begin
    if (found_o) begin
      assert_points_at_flag_R3: assert (flags_i[idx_o])
        else $error("tree index does not point at a set flag");
      assert_none_lower_R3: assert ((flags_i & ((N'(1) << idx_o) - N'(1))) == '0)
        else $error("tree skipped a lower flag");
    end else begin
      assert_empty_when_none_R6: assert (flags_i == '0)
        else $error("tree missed a flag");
    end
  end
endmodule

// File: rtl/phase_merge.sv
module phase_merge #(
  parameter int POS_W = tdc_enc_pkg::POS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             ph_i,
  output logic [POS_W:0]   code_o,
  output logic             hit_o
);
  logic             hold_vld_q;
  logic [POS_W-1:0] hold_pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_pos_q <= '0;
      code_o     <= '0;
      hit_o      <= 1'b0;
    end else if (!ph_i) begin
      hold_vld_q <= vld_i;
      hold_pos_q <= pos_i;
    end else if (hold_vld_q) begin
      hit_o  <= 1'b1;
      code_o <= {1'b0, hold_pos_q};  // first half wins
    end else if (vld_i) begin
      hit_o  <= 1'b1;
      code_o <= {1'b1, pos_i};
    end else begin
      hit_o  <= 1'b0;
      code_o <= '0;
    end
  end

  assert_dup_suppress_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i && hold_vld_q) |=> (hit_o && !code_o[POS_W]));

  assert_second_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i && !hold_vld_q && vld_i) |=> (hit_o && code_o[POS_W] && code_o[POS_W-1:0] == $past(pos_i)));

  assert_hold_mid_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_i |=> $stable({hit_o, code_o}));

  assert_no_hit_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> code_o == '0);
endmodule

// File: rtl/dual_phase_edge_enc.sv
module dual_phase_edge_enc #(
  parameter int TAPS = tdc_enc_pkg::TAPS_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TAPS-1:0]        therm_i,
  input  logic                   phase_i,
  output logic [$clog2(TAPS):0]  code_o,
  output logic                   hit_o
);
  localparam int POS_W = $clog2(TAPS);

  logic [TAPS-1:0]  therm_q, flag_d, flag_q;
  logic             ph1_q, ph2_q, ph3_q;
  logic             found_d, vld3_q;
  logic [POS_W-1:0] idx_d, pos3_q;

  edge_flags #(.TAPS(TAPS)) u_flags (
    .therm_i(therm_q),
    .flag_o (flag_d)
  );

  first_edge_tree #(.N(TAPS), .IDX_W(POS_W)) u_tree (
    .flags_i(flag_q),
    .found_o(found_d),
    .idx_o  (idx_d)
  );

  // Three fast stages: capture, flag, search
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_q <= '0;
      ph1_q   <= 1'b0;
      flag_q  <= '0;
      ph2_q   <= 1'b0;
      vld3_q  <= 1'b0;
      pos3_q  <= '0;
      ph3_q   <= 1'b0;
    end else begin
      therm_q <= therm_i;
      ph1_q   <= phase_i;
      flag_q  <= flag_d;
      ph2_q   <= ph1_q;
      vld3_q  <= found_d;
      pos3_q  <= idx_d;
      ph3_q   <= ph2_q;
    end
  end

  phase_merge #(.POS_W(POS_W)) u_merge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld3_q),
    .pos_i (pos3_q),
    .ph_i  (ph3_q),
    .code_o(code_o),
    .hit_o (hit_o)
  );

  assert_pos_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> code_o[POS_W-1:0] <= POS_W'(TAPS - tdc_enc_pkg::EDGE_SPAN));

  assert_search_tracks_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld3_q |-> $past(flag_q[idx_d]) || $past(flag_q) != '0);
endmodule

// File: tb/tb_dual_phase_edge_enc.sv
`timescale 1ns/1ps
module tb_dual_phase_edge_enc;
  localparam int TAPS = 128;
  localparam int WD_CYCLES = 150000;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [TAPS-1:0] therm_i = '0;
  logic           phase_i = 1'b0;
  logic [7:0]     code_o;
  logic           hit_o;

  int checks = 0;
  int errors = 0;
  logic ph_next = 1'b0;

  always #2.5 clk = ~clk;

  dual_phase_edge_enc #(.TAPS(TAPS)) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .therm_i(therm_i),
    .phase_i(phase_i),
    .code_o (code_o),
    .hit_o  (hit_o)
  );

  function automatic int first_edge(logic [TAPS-1:0] t);
    for (int k = 0; k + 2 < TAPS; k++)
      if (!t[k] && t[k+1] && t[k+2]) return k;
    return -1;
  endfunction

  function automatic logic [8:0] merge_pair(logic [TAPS-1:0] a, logic [TAPS-1:0] b);
    int ea, eb;
    ea = first_edge(a);
    eb = first_edge(b);
    if (ea >= 0) return {1'b1, 1'b0, 7'(ea)};
    if (eb >= 0) return {1'b1, 1'b1, 7'(eb)};
    return 9'd0;
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hit=%0d code=%0d expected hit=%0d code=%0d",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // Reference model: queue of recent samples, compared every cycle
  logic [TAPS-1:0] hist_t[$];
  logic            hist_p[$];
  logic [8:0]      model_exp = '0;
  bit              model_on = 1'b0;

  always @(posedge clk) begin
    if (rst_ni) begin
      hist_t.push_back(therm_i);
      hist_p.push_back(phase_i);
      if (hist_t.size() > 5) begin
        void'(hist_t.pop_front());
        void'(hist_p.pop_front());
      end
      if (hist_t.size() == 5 && hist_p[1])
        model_exp = merge_pair(hist_t[0], hist_t[1]);
    end
    #1;
    if (rst_ni && model_on) chk("R7 model", {hit_o, code_o}, model_exp);
  end

  task automatic drive(logic [TAPS-1:0] t);
    @(negedge clk);
    therm_i = t;
    phase_i = ph_next;
    ph_next = ~ph_next;
    @(posedge clk);
    #1;
  endtask

  task automatic run_pair(string tag, logic [TAPS-1:0] t0, logic [TAPS-1:0] t1, logic [8:0] exp);
    if (ph_next) drive('0);
    drive('0);
    drive('0);
    drive(t0);
    drive(t1);
    drive('0);
    drive('0);
    chk({tag, " R7 early"}, {hit_o, code_o}, 9'd0);
    drive('0);
    chk(tag, {hit_o, code_o}, exp);
    drive('0);
    chk({tag, " R7 held"}, {hit_o, code_o}, exp);
  endtask

  function automatic logic [TAPS-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [TAPS-1:0] gen_therm();
    logic [TAPS-1:0] t;
    int mode;
    mode = $urandom % 5;
    case (mode)
      0: t = '0;
      1: t = '1;
      2: t = {TAPS{1'b1}} << ($urandom % TAPS);
      3: begin
        t = {TAPS{1'b1}} << ($urandom % TAPS);
        t[$urandom % TAPS] = ~t[$urandom % TAPS];
        t ^= (TAPS'(1) << ($urandom % TAPS));
      end
      default: t = rnd_word();
    endcase
    return t;
  endfunction

  initial begin
    #(WD_CYCLES * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TAPS-1:0] ones;
    ones = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {hit_o, code_o}, 9'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_on = 1'b1;

    run_pair("R2 single edge", ones << 10, '0, {1'b1, 8'd9});
    run_pair("R2 bubble rejected", TAPS'(1) << 20, '0, 9'd0);
    run_pair("R3 lowest wins", (ones << 60) | (TAPS'(3) << 30), '0, {1'b1, 8'd29});
    run_pair("R4 second half", '0, ones << 50, {1'b1, 8'd177});
    run_pair("R5 duplicate dropped", ones << 100, ones << 5, {1'b1, 8'd99});
    run_pair("R6 all high", ones, ones, 9'd0);
    run_pair("R6 all low", '0, '0, 9'd0);
    run_pair("R8 tap zero", ones << 1, '0, {1'b1, 8'd0});
    run_pair("R8 top tap", ones << 126, '0, {1'b1, 8'd125});
    run_pair("R8 beyond end", ones << 127, ones << 127, 9'd0);
    run_pair("R4 second half low tap", TAPS'(1) << 40, ones << 3, {1'b1, 8'd130});

    for (int i = 0; i < 3000; i++) drive(gen_therm());
    repeat (6) drive('0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule